// File: doc/BRIEF.md
# Multicart Outer Bank Address Extender

This block sits next to an existing inner bank-switching controller on a cartridge and widens that controller's bank numbers with a small outer register. The CPU loads the outer register by writing anywhere in the $6000-$7FFF window. The value loaded is the low byte of the write address, and the data bus plays no part. The block only watches these writes. It never blocks them, so the inner controller and the work-RAM path still receive every one.

The outer register holds a two-bit outer bank field and a mode bit. In normal mode the outer field is placed above the inner controller's 8 KiB program page and 1 KiB pattern page. In fixed mode the program side ignores the inner controller and maps a linear 32 KiB window selected by the outer field, while the pattern side keeps its normal mapping. Final bank numbers are reduced modulo the number of banks fitted, and that number need not be a power of two. The block forms full memory addresses from each final bank and the in-bank offset.

Top module: `outer_bank_ext`

## Requirements
- R1: On a clock edge where `cpu_wr` is 1 and `cpu_addr[15:13]` is 3'b011 ($6000-$7FFF), the outer register loads `cpu_addr[7:0]`. Its bits [5:4] are the outer field OB and bit [3] is the mode bit FX.
- R2: A strobe outside $6000-$7FFF, or an address in that window with `cpu_wr` at 0, leaves the outer register and every bank output unchanged.
- R3: With FX=0 the raw program bank is OB*16 + (`inner_prg_page` mod 16).
- R4: With FX=1 the raw program bank is OB*4 + `cpu_addr[14:13]`, whatever `inner_prg_page` is.
- R5: The raw pattern bank is OB*128 + (`inner_chr_page` mod 128) for either value of FX.
- R6: `prg_bank` is the raw program bank mod PRG_BANKS and `chr_bank` is the raw pattern bank mod CHR_BANKS. A count of zero drives the bank to 0.
- R7: Reset clears the outer register to 0, so `prg_bank` follows the low nibble of the inner page with OB=0 in normal mode.
- R8: `prg_rom_addr` equals `prg_bank`*8192 + `cpu_addr[12:0]`, and `chr_rom_addr` equals `chr_bank`*1024 + `ppu_addr[9:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | CPU write strobe, sampled on the clock edge |
| inner_prg_page | input | 8 | 8 KiB program page from the inner controller |
| ppu_addr | input | 14 | Pattern-side address bus |
| inner_chr_page | input | 8 | 1 KiB pattern page from the inner controller |
| prg_bank | output | 6 | Final 8 KiB program bank |
| prg_rom_addr | output | 19 | Program memory byte address |
| chr_bank | output | 9 | Final 1 KiB pattern bank |
| chr_rom_addr | output | 19 | Pattern memory byte address |

## Verification
The assertions check the register side on every cycle. They confirm that each in-window write loads the address byte, that the register holds steady when no such write occurs, that the bank outputs stay below the fitted counts, and that the program bank in fixed mode does not move when only the inner page changes. The bench scenarios show the arithmetic. They cover the outer-field offsets in both modes, the four fixed slots, modulo wrap at non-power-of-two counts, zero-count instances, the memory address composition, and the state after reset.

// File: rtl/outer_bank_ext.sv
module outer_bank_ext #(
  parameter int PRG_BANKS = 48,
  parameter int CHR_BANKS = 96,
  parameter int OB_W      = 2,
  parameter int PRG_IN_W  = 4,
  parameter int CHR_IN_W  = 7,
  parameter int PRG_OFS_W = 13,
  parameter int CHR_OFS_W = 10,
  localparam int PRG_BW   = OB_W + PRG_IN_W,
  localparam int CHR_BW   = OB_W + CHR_IN_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [15:0]                   cpu_addr,
  input  logic                          cpu_wr,
  input  logic [7:0]                    inner_prg_page,
  input  logic [13:0]                   ppu_addr,
  input  logic [7:0]                    inner_chr_page,
  output logic [PRG_BW-1:0]             prg_bank,
  output logic [PRG_BW+PRG_OFS_W-1:0]   prg_rom_addr,
  output logic [CHR_BW-1:0]             chr_bank,
  output logic [CHR_BW+CHR_OFS_W-1:0]   chr_rom_addr
);

  logic [7:0]        outer_q;
  logic              win_wr;
  logic [OB_W-1:0]   ob;
  logic              fx;
  logic [PRG_BW-1:0] prg_raw;
  logic [CHR_BW-1:0] chr_raw;

  assign win_wr = cpu_wr && (cpu_addr[15:13] == 3'b011);

  always_ff @(posedge clk) begin
    if (!rst_n)      outer_q <= '0;
    else if (win_wr) outer_q <= cpu_addr[7:0];
  end

  assign ob = outer_q[4 +: OB_W];
  assign fx = outer_q[3];

  always_comb begin
    if (fx) prg_raw = PRG_BW'({ob, cpu_addr[14:13]});
    else    prg_raw = {ob, inner_prg_page[PRG_IN_W-1:0]};
  end

  assign chr_raw = {ob, inner_chr_page[CHR_IN_W-1:0]};

  generate
    if (PRG_BANKS == 0) begin : g_prg_none
      assign prg_bank = '0;
    end else begin : g_prg_mod
      assign prg_bank = PRG_BW'(int'(prg_raw) % PRG_BANKS);
    end
    if (CHR_BANKS == 0) begin : g_chr_none
      assign chr_bank = '0;
    end else begin : g_chr_mod
      assign chr_bank = CHR_BW'(int'(chr_raw) % CHR_BANKS);
    end
  endgenerate

  assign prg_rom_addr = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
  assign chr_rom_addr = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};

endmodule

module outer_bank_ext_chk #(
  parameter int PRG_BANKS = 48,
  parameter int CHR_BANKS = 96,
  parameter int PRG_BW    = 6,
  parameter int CHR_BW    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       cpu_addr,
  input logic              cpu_wr,
  input logic [7:0]        inner_prg_page,
  input logic [7:0]        outer_q,
  input logic [PRG_BW-1:0] prg_bank,
  input logic [CHR_BW-1:0] chr_bank
);

  a_r1_latch_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=> outer_q == $past(cpu_addr[7:0]));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15:13] == 3'b011) |=> $stable(outer_q));

  a_r4_fixed_no_inner: assert property (@(posedge clk) disable iff (!rst_n)
    (outer_q[3] && $stable(outer_q) && $stable(cpu_addr[14:13]) && !$stable(inner_prg_page))
      |-> $stable(prg_bank));

  a_r6_prg_range: assert property (@(posedge clk) disable iff (!rst_n)
    PRG_BANKS == 0 ? prg_bank == '0 : int'(prg_bank) < PRG_BANKS);

  a_r6_chr_range: assert property (@(posedge clk) disable iff (!rst_n)
    CHR_BANKS == 0 ? chr_bank == '0 : int'(chr_bank) < CHR_BANKS);

endmodule

bind outer_bank_ext outer_bank_ext_chk #(
  .PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .PRG_BW(PRG_BW), .CHR_BW(CHR_BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .inner_prg_page(inner_prg_page), .outer_q(outer_q),
  .prg_bank(prg_bank), .chr_bank(chr_bank)
);

// File: tb/outer_bank_ext_test.sv
`timescale 1ns/100ps
module outer_bank_ext_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] cpu_addr = 16'h8000;
  logic        cpu_wr = 0;
  logic [7:0]  inner_prg_page = 8'h05;
  logic [13:0] ppu_addr = '0;
  logic [7:0]  inner_chr_page = 8'd10;
  logic [5:0]  prg_bank, zprg_bank;
  logic [18:0] prg_rom_addr, zprg_rom_addr;
  logic [8:0]  chr_bank, zchr_bank;
  logic [18:0] chr_rom_addr, zchr_rom_addr;
  int tests = 0, fails = 0;
  bit done = 0;
  int cur_ob = 0, cur_fx = 0;

  always #2.5 clk = ~clk;

  outer_bank_ext uut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .inner_prg_page(inner_prg_page), .ppu_addr(ppu_addr), .inner_chr_page(inner_chr_page),
    .prg_bank(prg_bank), .prg_rom_addr(prg_rom_addr), .chr_bank(chr_bank), .chr_rom_addr(chr_rom_addr));

  outer_bank_ext #(.PRG_BANKS(0), .CHR_BANKS(0)) uut_z (.clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .inner_prg_page(inner_prg_page), .ppu_addr(ppu_addr),
    .inner_chr_page(inner_chr_page), .prg_bank(zprg_bank), .prg_rom_addr(zprg_rom_addr),
    .chr_bank(zchr_bank), .chr_rom_addr(zchr_rom_addr));

  function automatic int exp_prg(int ob, int fx, int inner, int addr);
    int raw = fx ? ob * 4 + ((addr / 8192) % 4) : ob * 16 + (inner % 16);
    return raw % 48;
  endfunction

  function automatic int exp_chr(int ob, int inner);
    return (ob * 128 + (inner % 128)) % 96;
  endfunction

  task automatic check(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(logic [15:0] a);
    @(negedge clk); cpu_addr = a; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
    if (a[15:13] == 3'b011) begin cur_ob = int'(a[5:4]); cur_fx = int'(a[3]); end
  endtask

  task automatic look(logic [15:0] a, logic [7:0] ip);
    cpu_addr = a; inner_prg_page = ip; #1;
  endtask

  task automatic t_reset;
    look(16'h8000, 8'h05);
    check("R7 reset prg", int'(prg_bank), 5);
    check("R7 reset chr", int'(chr_bank), 10);
  endtask

  task automatic t_latch;
    wr(16'h7F10);
    look(16'h8000, 8'h05);
    check("R1 latch 7F10 prg", int'(prg_bank), 21);
    wr(16'h6022);
    look(16'h8000, 8'h05);
    check("R1 latch 6022 prg", int'(prg_bank), exp_prg(2, 0, 5, 16'h8000));
  endtask

  task automatic t_ignore;
    wr(16'h5F38);
    look(16'h8000, 8'h05);
    check("R2 below window", int'(prg_bank), 37);
    wr(16'h8038);
    look(16'h8000, 8'h05);
    check("R2 above window", int'(prg_bank), 37);
    @(negedge clk); cpu_addr = 16'h6038; cpu_wr = 0;
    @(negedge clk);
    look(16'h8000, 8'h05);
    check("R2 no strobe", int'(prg_bank), 37);
  endtask

  task automatic t_normal;
    wr(16'h6020);
    look(16'hA000, 8'h1F);
    check("R3 ob2 inner1F", int'(prg_bank), 47);
    look(16'hE000, 8'h00);
    check("R3 ob2 inner0", int'(prg_bank), 32);
  endtask

  task automatic t_fixed;
    wr(16'h6018);
    for (int s = 0; s < 4; s++) begin
      look(16'(16'h8000 + s * 16'h2000), 8'h0B);
      check("R4 fixed slot", int'(prg_bank), 4 + s);
    end
    look(16'hE000, 8'h03);
    check("R4 fixed inner ignored", int'(prg_bank), 7);
    wr(16'h6038);
    look(16'hC000, 8'h0B);
    check("R4 fixed ob3", int'(prg_bank), exp_prg(3, 1, 11, 16'hC000));
  endtask

  task automatic t_chr;
    wr(16'h6010);
    inner_chr_page = 8'd0; #1;
    check("R5 chr ob1 normal", int'(chr_bank), exp_chr(1, 0));
    wr(16'h6018);
    #1;
    check("R5 chr ob1 fixed", int'(chr_bank), 32);
    inner_chr_page = 8'hFF; #1;
    check("R5 chr inner masked", int'(chr_bank), exp_chr(1, 255));
  endtask

  task automatic t_wrap;
    wr(16'h6030);
    look(16'h8000, 8'h02);
    check("R6 prg wrap", int'(prg_bank), 2);
    inner_chr_page = 8'd5; #1;
    check("R6 chr wrap", int'(chr_bank), exp_chr(3, 5));
    check("R6 zero prg", int'(zprg_bank), 0);
    check("R6 zero chr", int'(zchr_bank), 0);
  endtask

  task automatic t_addr;
    wr(16'h6010);
    look(16'hB234, 8'h03);
    ppu_addr = 14'h1ABC; inner_chr_page = 8'd7; #1;
    check("R8 prg addr", int'(prg_rom_addr), exp_prg(cur_ob, cur_fx, 3, 16'hB234) * 8192 + 16'h1234);
    check("R8 chr addr", int'(chr_rom_addr), exp_chr(cur_ob, 7) * 1024 + 14'h2BC);
  endtask

  task automatic t_rereset;
    wr(16'h6038);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    look(16'hE000, 8'h09);
    check("R7 rereset prg", int'(prg_bank), 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_latch; t_ignore; t_normal; t_fixed; t_chr; t_wrap; t_addr; t_rereset;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule